// File: doc/BRIEF.md
# Linked-Descriptor Serial Flash Transfer Engine

This block moves data between system memory and a serial NOR flash over a single data lane. Software builds a chain of transfer descriptors in memory, each naming a buffer, a successor and a control word, and starts the engine by writing the address of the first descriptor into the pointer register. The engine fetches each descriptor over its memory port. It then shifts the buffer out to the flash, or fills the buffer from the flash, and follows the successor pointer until it reaches a zero pointer. When the chain is finished it raises a sticky chain-done status bit.

A descriptor is three little-endian 32-bit words at consecutive word addresses: buffer address, successor pointer, control word. A descriptor can keep the serial transaction open into the next one, so a command and its data phase form one bus transaction even though they sit in separate buffers. Chip select is driven outside this block. The `xact_open` pin shows when a transaction is open, so external logic can frame it. The serial clock toggles only while a byte is being shifted.

The memory port uses valid/ready request handshakes. A request, with its address, direction, size flag and write data, must stay unchanged while `mem_req_valid` is high and `mem_req_ready` is low. It is accepted on the first clock edge where both are high. At most one request is outstanding. A read is answered by exactly one `mem_rsp_valid` pulse, after any number of cycles, and the block always accepts that response. A write completes when it is accepted and gets no response.

Top module: `flash_chain_dma`

## Requirements
- R1: After reset, `sclk`, `mosi`, `xact_open` and `mem_req_valid` are low, and the status register (register address 1) reads zero.
- R2: A write to register address 0 while the engine is idle starts a chain at the written pointer. A descriptor is fetched as three word reads (`mem_req_word`=1) at pointer, pointer+4 and pointer+8, which return buffer address, successor pointer and control word.
- R3: Control word fields: bit 0 is the direction (1 = memory to flash, 0 = flash to memory), bits 3:1 are the lane mode (1 = single-lane SDR; 2, 3, 5, 6, 7 = wider or DDR modes), bit 8 keeps the transaction open, and bits 31:16 are the byte count.
- R4: For direction 1, the bytes are read from memory at ascending addresses starting at the buffer address and shifted MSB first in SPI mode 0. `sclk` idles low, and `mosi` holds steady while `sclk` is high.
- R5: For direction 0, `miso` is sampled on each rising `sclk` edge and assembled MSB first. Each byte is written to memory at ascending addresses starting at the buffer address, while `mosi` carries zeros.
- R6: A zero successor pointer ends the chain. When the chain ends, bit 31 of the status register is set.
- R7: The transaction opens (`xact_open` rises) when the first shifted descriptor starts. It stays open across a descriptor whose bit 8 is set and that has a successor. It closes after a shifted descriptor with bit 8 clear, or at the end of the chain, and each close sets status bit 16.
- R8: A descriptor whose mode is not 1, whose count is zero, or whose count exceeds 0xFFC0 is skipped. It produces no `sclk` edges and no data access, and the chain goes on or ends normally.
- R9: Writing ones to status bits clears them and zeros leave them unchanged. All other status bits read zero.
- R10: While a chain is running, a write to register address 0 is ignored.
- R11: Starting with a zero pointer makes no memory request and sets status bit 31 at once.
- R12: A memory request held without ready keeps its address and direction unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 pointer/launch, 1 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = byte write, 0 = read |
| mem_req_word | output | 1 | 1 = 32-bit descriptor read, 0 = byte access |
| mem_req_addr | output | 32 | Byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read data (byte reads use bits 7:0) |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| xact_open | output | 1 | Serial transaction currently open |

## Verification
The bench attacks the transaction boundaries. It uses chains where a skipped descriptor sits between or after shifted ones, and chains whose last descriptor still has the keep-open bit set. A design that let a skipped descriptor close the transaction, or that honoured the keep-open bit on the last descriptor, shows the wrong number of `xact_open` rises or a missing status bit 16. A bit-order or sampling-edge error shows up as a mismatch against an independently generated flash read pattern and captured output stream. An engine that touched a skipped buffer shows up because skipped read buffers are pre-filled with a marker. A launch written mid-chain, and a zero start pointer, check that the pointer register neither restarts a running engine nor fetches from address zero.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_FWAIT, ST_DECODE,
    ST_MRD, ST_MRWAIT, ST_SHIFT, ST_MWR, ST_NEXT
  } eng_state_t;

  localparam int CTL_DIR     = 0;
  localparam int CTL_MODE_LO = 1;
  localparam int CTL_FRAG    = 8;
  localparam int CTL_LEN_LO  = 16;
  localparam logic [2:0] MODE_SDR1 = 3'd1;
  localparam int STAT_CHAIN = 31;
  localparam int STAT_TXN   = 16;
endpackage

// File: rtl/fcd_shifter.sv
module fcd_shifter #(
  parameter int HALF_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx,
  output logic       sclk,
  output logic       mosi
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] tmr;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; rx <= '0; sclk <= 1'b0; mosi <= 1'b0;
      tmr <= '0; bitn <= '0; sh <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; sh <= tx; mosi <= tx[7]; bitn <= '0; tmr <= '0; sclk <= 1'b0;
        end
      end else if (tmr != CW'(HALF_CYC - 1)) begin
        tmr <= tmr + 1'b1;
      end else begin
        tmr <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            busy <= 1'b0; done <= 1'b1; mosi <= 1'b0;
          end else begin
            bitn <= bitn + 3'd1;
            sh   <= {sh[6:0], 1'b0};
            mosi <= sh[6];
          end
        end
      end
    end
  end

  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sclk);
  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n) sclk |-> $stable(mosi));
  assert_start_idle_R4: assert property (@(posedge clk) disable iff (!rst_n) start |-> !busy);
endmodule

// File: rtl/fcd_regs.sv
module fcd_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        eng_busy,
  input  logic        ev_chain,
  input  logic        ev_txn,
  output logic        launch,
  output logic [31:0] reg_rdata
);
  import fcd_pkg::*;

  logic        s_chain, s_txn;
  logic [31:0] ptr_q;
  logic        wr_stat;

  assign launch  = reg_we && (reg_addr == 2'd0) && !eng_busy;
  assign wr_stat = reg_we && (reg_addr == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_chain <= 1'b0; s_txn <= 1'b0; ptr_q <= '0;
    end else begin
      if (launch) ptr_q <= reg_wdata;
      s_chain <= ev_chain | (s_chain & ~(wr_stat & reg_wdata[STAT_CHAIN]));
      s_txn   <= ev_txn   | (s_txn   & ~(wr_stat & reg_wdata[STAT_TXN]));
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata = ptr_q;
      2'd1: begin
        reg_rdata[STAT_CHAIN] = s_chain;
        reg_rdata[STAT_TXN]   = s_txn;
      end
      default: reg_rdata = '0;
    endcase
  end

  assert_w1c_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(s_chain) |-> $past(wr_stat && reg_wdata[STAT_CHAIN]));
  assert_w1c_txn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(s_txn) |-> $past(wr_stat && reg_wdata[STAT_TXN]));
endmodule

// File: rtl/fcd_engine.sv
module fcd_engine #(
  parameter logic [15:0] MAX_LEN = 16'hFFC0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  logic [31:0] launch_ptr,
  output logic        busy,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic        mem_req_word,
  output logic [31:0] mem_req_addr,
  output logic [7:0]  mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        sh_start,
  output logic [7:0]  sh_tx,
  input  logic        sh_busy,
  input  logic        sh_done,
  input  logic [7:0]  sh_rx,
  output logic        xact_open,
  output logic        ev_chain,
  output logic        ev_txn
);
  import fcd_pkg::*;

  eng_state_t  state;
  logic [31:0] desc_ptr, baddr, nxt;
  logic [1:0]  widx;
  logic [15:0] remaining, c_len;
  logic        c_dir, c_frag, ran;
  logic [2:0]  c_mode;
  logic [7:0]  byte_r;
  logic        desc_ok, last_byte;

  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_FETCH) || (state == ST_MRD) || (state == ST_MWR);
  assign mem_req_write = (state == ST_MWR);
  assign mem_req_word  = (state == ST_FETCH);
  assign mem_req_addr  = (state == ST_FETCH) ? desc_ptr + {28'd0, widx, 2'b00} : baddr;
  assign mem_req_wdata = byte_r;
  assign desc_ok   = (c_mode == MODE_SDR1) && (c_len != 16'd0) && (c_len <= MAX_LEN);
  assign last_byte = (remaining == 16'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; desc_ptr <= '0; baddr <= '0; nxt <= '0; widx <= '0;
      remaining <= '0; c_len <= '0; c_dir <= 1'b0; c_frag <= 1'b0; c_mode <= '0;
      ran <= 1'b0; byte_r <= '0; sh_start <= 1'b0; sh_tx <= '0;
      xact_open <= 1'b0; ev_chain <= 1'b0; ev_txn <= 1'b0;
    end else begin
      sh_start <= 1'b0;
      ev_chain <= 1'b0;
      ev_txn   <= 1'b0;
      case (state)
        ST_IDLE: if (launch) begin
          if (launch_ptr == 32'd0) ev_chain <= 1'b1;
          else begin
            desc_ptr <= launch_ptr; widx <= '0; state <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_req_ready) state <= ST_FWAIT;
        ST_FWAIT: if (mem_rsp_valid) begin
          case (widx)
            2'd0: baddr <= mem_rsp_data;
            2'd1: nxt   <= mem_rsp_data;
            default: begin
              c_dir  <= mem_rsp_data[CTL_DIR];
              c_mode <= mem_rsp_data[CTL_MODE_LO +: 3];
              c_frag <= mem_rsp_data[CTL_FRAG];
              c_len  <= mem_rsp_data[CTL_LEN_LO +: 16];
            end
          endcase
          if (widx == 2'd2) state <= ST_DECODE;
          else begin
            widx <= widx + 2'd1; state <= ST_FETCH;
          end
        end
        ST_DECODE: begin
          ran <= desc_ok;
          if (desc_ok) begin
            remaining <= c_len;
            xact_open <= 1'b1;
            if (c_dir) state <= ST_MRD;
            else begin
              sh_tx <= 8'h00; sh_start <= 1'b1; state <= ST_SHIFT;
            end
          end else state <= ST_NEXT;
        end
        ST_MRD: if (mem_req_ready) state <= ST_MRWAIT;
        ST_MRWAIT: if (mem_rsp_valid) begin
          sh_tx <= mem_rsp_data[7:0]; sh_start <= 1'b1; state <= ST_SHIFT;
        end
        ST_SHIFT: if (sh_done) begin
          if (c_dir) begin
            baddr <= baddr + 32'd1; remaining <= remaining - 16'd1;
            state <= last_byte ? ST_NEXT : ST_MRD;
          end else begin
            byte_r <= sh_rx; state <= ST_MWR;
          end
        end
        ST_MWR: if (mem_req_ready) begin
          baddr <= baddr + 32'd1; remaining <= remaining - 16'd1;
          if (last_byte) state <= ST_NEXT;
          else begin
            sh_tx <= 8'h00; sh_start <= 1'b1; state <= ST_SHIFT;
          end
        end
        ST_NEXT: begin
          if (xact_open && ((nxt == 32'd0) || (ran && !c_frag))) begin
            xact_open <= 1'b0; ev_txn <= 1'b1;
          end
          if (nxt == 32'd0) begin
            ev_chain <= 1'b1; state <= ST_IDLE;
          end else begin
            desc_ptr <= nxt; widx <= '0; state <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));
  assert_chain_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_chain |-> !xact_open);
  assert_quiet_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NEXT) |-> !sh_busy);
endmodule

// File: rtl/flash_chain_dma.sv
module flash_chain_dma #(
  parameter int          HALF_CYC = 2,
  parameter logic [15:0] MAX_LEN  = 16'hFFC0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic        mem_req_word,
  output logic [31:0] mem_req_addr,
  output logic [7:0]  mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        xact_open
);
  logic       launch, eng_busy, ev_chain, ev_txn;
  logic       sh_start, sh_busy, sh_done;
  logic [7:0] sh_tx, sh_rx;

  fcd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .eng_busy(eng_busy), .ev_chain(ev_chain),
    .ev_txn(ev_txn), .launch(launch), .reg_rdata(reg_rdata)
  );

  fcd_engine #(.MAX_LEN(MAX_LEN)) u_eng (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_ptr(reg_wdata),
    .busy(eng_busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_word(mem_req_word),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .sh_start(sh_start), .sh_tx(sh_tx), .sh_busy(sh_busy), .sh_done(sh_done),
    .sh_rx(sh_rx), .xact_open(xact_open), .ev_chain(ev_chain), .ev_txn(ev_txn)
  );

  fcd_shifter #(.HALF_CYC(HALF_CYC)) u_shf (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx), .miso(miso),
    .busy(sh_busy), .done(sh_done), .rx(sh_rx), .sclk(sclk), .mosi(mosi)
  );
endmodule

// File: tb/flash_chain_dma_test.sv
`timescale 1ns/1ps
module flash_chain_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd1;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid, mem_req_write, mem_req_word;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        sclk, mosi, miso, xact_open;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  flash_chain_dma uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_word(mem_req_word),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .xact_open(xact_open)
  );

  // memory model
  logic [7:0] mem [1024];
  logic       pend = 1'b0;
  int         pdly = 0;
  logic [9:0] pa = '0;
  logic       pw = 1'b0;
  int         nreq = 0;

  function automatic logic [31:0] rd_word(logic [9:0] a);
    return {mem[a + 10'd3], mem[a + 10'd2], mem[a + 10'd1], mem[a]};
  endfunction

  always @(posedge clk) begin
    mem_req_ready <= ($urandom % 4) != 0;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      nreq <= nreq + 1;
      if (mem_req_write) mem[mem_req_addr[9:0]] <= mem_req_wdata;
      else begin
        pend <= 1'b1; pdly <= $urandom % 3; pa <= mem_req_addr[9:0]; pw <= mem_req_word;
      end
    end
    if (pend) begin
      if (pdly == 0) begin
        pend <= 1'b0;
        mem_rsp_valid <= 1'b1;
        mem_rsp_data <= pw ? rd_word(pa) : {24'd0, mem[pa]};
      end else pdly <= pdly - 1;
    end
  end

  // flash model
  function automatic logic [7:0] pat(int g);
    logic [7:0] a;
    a = g[7:0] * 8'd29 + 8'h5A;
    return a ^ g[10:3];
  endfunction

  int         gbit = 0;
  int         ncap = 0;
  logic [7:0] capsh = '0;
  logic [7:0] cap [256];
  logic [7:0] cur_pat;
  assign cur_pat = pat(gbit / 8);
  assign miso = cur_pat[~gbit[2:0]];

  always @(posedge sclk) begin
    gbit  <= gbit + 1;
    capsh <= {capsh[6:0], mosi};
    if (gbit[2:0] == 3'd7) begin
      cap[ncap % 256] <= {capsh[6:0], mosi};
      ncap <= ncap + 1;
    end
  end

  int   nopen = 0;
  logic xprev = 1'b0;
  always @(posedge clk) begin
    xprev <= xact_open;
    if (xact_open && !xprev) nopen <= nopen + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // descriptor set under test
  int          nd;
  logic        d_dir [3];
  logic [2:0]  d_mode [3];
  logic [15:0] d_len [3];
  logic        d_frag [3];

  function automatic logic [31:0] slot(int i); return 32'h40 + 32'(16 * i); endfunction
  function automatic logic [31:0] bufa(int i); return 32'h100 + 32'(64 * i); endfunction
  function automatic bit dvalid(int i);
    return d_mode[i] == 3'd1 && d_len[i] != 16'd0 && d_len[i] <= 16'hFFC0;
  endfunction

  task automatic put32(logic [31:0] a, logic [31:0] v);
    for (int b = 0; b < 4; b++) mem[a[9:0] + 10'(b)] = v[8*b +: 8];
  endtask

  task automatic prep_chain();
    for (int i = 0; i < nd; i++) begin
      put32(slot(i), bufa(i));
      put32(slot(i) + 4, (i < nd - 1) ? slot(i + 1) : 32'd0);
      put32(slot(i) + 8, {d_len[i], 7'd0, d_frag[i], 4'd0, d_mode[i], d_dir[i]});
      for (int j = 0; j < 8; j++)
        mem[bufa(i)[9:0] + 10'(j)] = d_dir[i] ? 8'($urandom) : 8'hEE;
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int t = 0; t < 20000; t++) begin
      @(negedge clk);
      if (reg_rdata[31]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_chain(input bit interfere);
    int base_cap, base_g, base_open, k, exp_open, bad_tx, bad_rx, bad_skip;
    bit ok, open, any;
    logic [7:0] exp_b;
    reg_write(2'd1, 32'hFFFF_FFFF);
    base_cap = ncap; base_g = gbit / 8; base_open = nopen;
    reg_write(2'd0, slot(0));
    if (interfere) begin
      repeat (20) @(negedge clk);
      reg_write(2'd0, slot(1));
    end
    wait_done(ok);
    chk(ok, "R6", "chain done bit 31 within timeout", {31'd0, ok}, 32'd1);
    if (!ok) return;
    repeat (4) @(negedge clk);
    k = 0; bad_tx = 0; bad_rx = 0; bad_skip = 0; open = 0; exp_open = 0; any = 0;
    for (int i = 0; i < nd; i++) begin
      if (dvalid(i)) begin
        any = 1;
        if (!open) begin exp_open++; open = 1; end
        for (int j = 0; j < int'(d_len[i]); j++) begin
          exp_b = d_dir[i] ? mem[bufa(i)[9:0] + 10'(j)] : 8'h00;
          if (cap[(base_cap + k) % 256] !== exp_b) begin
            if (bad_tx == 0)
              $display("FAIL R4 tx byte %0d of desc %0d actual=%h expected=%h",
                       j, i, cap[(base_cap + k) % 256], exp_b);
            bad_tx++;
          end
          if (!d_dir[i] && mem[bufa(i)[9:0] + 10'(j)] !== pat(base_g + k)) begin
            if (bad_rx == 0)
              $display("FAIL R5 rx byte %0d of desc %0d actual=%h expected=%h",
                       j, i, mem[bufa(i)[9:0] + 10'(j)], pat(base_g + k));
            bad_rx++;
          end
          k++;
        end
        if (!d_frag[i] || i == nd - 1) open = 0;
      end else begin
        if (!d_dir[i] && mem[bufa(i)[9:0]] !== 8'hEE) bad_skip++;
        if (i == nd - 1) open = 0;
      end
    end
    checks += 2;
    if (bad_tx != 0) errors++;
    if (bad_rx != 0) errors++;
    chk(ncap - base_cap == k, "R8", "shifted byte count", ncap - base_cap, k);
    chk(bad_skip == 0, "R8", "skipped buffer untouched", bad_skip, 0);
    chk(nopen - base_open == exp_open, "R7", "transaction openings", nopen - base_open, exp_open);
    chk(reg_rdata[16] == any, "R7", "status bit 16", {31'd0, reg_rdata[16]}, {31'd0, any});
    chk(!xact_open && !sclk, "R6", "quiet after chain", {30'd0, xact_open, sclk}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    int n0;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sclk && !mosi && !xact_open && !mem_req_valid, "R1", "idle pins after reset",
        {28'd0, sclk, mosi, xact_open, mem_req_valid}, 0);
    chk(reg_rdata == 0, "R1", "status after reset", reg_rdata, 0);

    // R2 R3 R4: single write descriptor
    nd = 1; d_dir[0] = 1; d_mode[0] = 1; d_len[0] = 3; d_frag[0] = 0;
    prep_chain(); run_chain(0);
    // R5: single read descriptor
    d_dir[0] = 0; d_len[0] = 4;
    prep_chain(); run_chain(0);
    // R7: write keeps open into read -> one transaction
    nd = 2; d_dir[0] = 1; d_len[0] = 2; d_frag[0] = 1;
    d_dir[1] = 0; d_mode[1] = 1; d_len[1] = 3; d_frag[1] = 0;
    prep_chain(); run_chain(0);
    // R7: fragment clear splits into two transactions
    d_frag[0] = 0;
    prep_chain(); run_chain(0);
    // R8: lone unsupported mode
    nd = 1; d_dir[0] = 0; d_mode[0] = 3'd3; d_len[0] = 2; d_frag[0] = 0;
    prep_chain(); run_chain(0);
    // R8: zero length and oversize in the middle, last keeps fragment set
    nd = 3; d_dir[0] = 1; d_mode[0] = 1; d_len[0] = 2; d_frag[0] = 1;
    d_dir[1] = 0; d_mode[1] = 1; d_len[1] = 16'hFFC1; d_frag[1] = 1;
    d_dir[2] = 0; d_mode[2] = 1; d_len[2] = 2; d_frag[2] = 1;
    prep_chain(); run_chain(0);
    d_len[1] = 0;
    prep_chain(); run_chain(0);

    // R9: write-one-to-clear per bit
    chk(reg_rdata == 32'h8001_0000, "R9", "both status bits set", reg_rdata, 32'h8001_0000);
    reg_write(2'd1, 32'h0001_0000);
    @(negedge clk);
    chk(reg_rdata == 32'h8000_0000, "R9", "clear bit 16 only", reg_rdata, 32'h8000_0000);
    reg_write(2'd1, 32'h7FFE_FFFF);
    @(negedge clk);
    chk(reg_rdata == 32'h8000_0000, "R9", "zeros leave bit 31", reg_rdata, 32'h8000_0000);
    reg_write(2'd1, 32'h8000_0000);
    @(negedge clk);
    chk(reg_rdata == 0, "R9", "clear bit 31", reg_rdata, 0);

    // R11: zero pointer
    n0 = nreq;
    reg_write(2'd0, 32'd0);
    repeat (3) @(negedge clk);
    chk(reg_rdata == 32'h8000_0000, "R11", "zero pointer done", reg_rdata, 32'h8000_0000);
    chk(nreq == n0, "R11", "no memory request", nreq - n0, 0);

    // R10: launch while busy ignored
    nd = 2; d_dir[0] = 1; d_mode[0] = 1; d_len[0] = 6; d_frag[0] = 0;
    d_dir[1] = 1; d_mode[1] = 1; d_len[1] = 5; d_frag[1] = 0;
    prep_chain();
    put32(slot(0) + 4, 32'd0);
    nd = 1;
    n0 = ncap;
    run_chain(1);
    reg_write(2'd1, 32'hFFFF_FFFF);
    repeat (300) @(negedge clk);
    chk(ncap - n0 == 6, "R10", "mid-chain launch ignored", ncap - n0, 6);
    chk(reg_rdata == 0, "R10", "no second chain", reg_rdata, 0);

    // random chains (R2..R8, R12 under random ready/latency)
    for (int it = 0; it < 20; it++) begin
      nd = 1 + ($urandom % 3);
      for (int i = 0; i < 3; i++) begin
        d_dir[i]  = 1'($urandom);
        d_mode[i] = (($urandom % 5) != 0) ? 3'd1 : 3'($urandom);
        d_len[i]  = (($urandom % 8) == 0) ? 16'd0 : 16'(1 + $urandom % 6);
        d_frag[i] = (($urandom % 6) != 0);
      end
      prep_chain(); run_chain(0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule